// File: doc/BRIEF.md
# Packed-BCD Calendar Clock Register File

This block is a byte-wide memory-mapped store with a calendar clock in its top sixteen byte locations. Seconds, minutes, hours, day of week, date, month and year are kept as packed BCD counters. Each byte holds its tens digit in the upper bits and its units digit in the low nibble. The counters advance on a one-cycle `tick` pulse, which the system supplies once per second. A century-toggle bit and its enable share a byte with the day of week. A stop bit in the seconds byte freezes the clock. Addresses below the clock window reach a plain byte RAM.

A small bus state machine decodes each cycle into one of four states. BUS_IDLE means chip-enable is low. BUS_READ means chip-enable is high and write-enable is low. BUS_WRITE means both are high. BUS_PFAIL means the power-fail input is high. The next state is chosen again on every clock edge, and any state can follow any other. BUS_PFAIL wins over the others, and BUS_WRITE wins over BUS_READ. Read data is registered: after a BUS_READ cycle, `rdata` carries the addressed byte. In every other state `rdata` is zero. While power-fail is high, writes are discarded but the clock keeps counting. The eight bytes between the flags byte and the seconds byte are plain storage that the clock does not use.

Top module: `rtc_regfile`

## Requirements
- R1: The clock window is the addresses whose bits above bit 3 are all ones (0x1FF0–0x1FFF at the default width). The byte layouts are as follows. 0x1FF9 holds {stop, sec tens[2:0], sec units}. 0x1FFA holds {0, min tens[2:0], units}. 0x1FFB holds {00, hour tens[1:0], units}. 0x1FFC holds {0, freq-test, century bit, century enable, 0, day[2:0]}. 0x1FFD holds {00, date tens[1:0], units}. 0x1FFE holds {000, month tens, units}. 0x1FFF holds year {tens, units}.
- R2: Bits outside the fields of R1 read as zero, whatever value was written to them.
- R3: The byte at 0x1FF0 always reads 0x00. Writes to it are ignored.
- R4: Each `tick` with the stop bit clear advances seconds. Each field carries into the next at the end of its range: seconds and minutes wrap 59→00, hours 23→00, day 7→1, month 12→01, year 99→00. On an hour carry the day of week and the date both advance.
- R5: The date rolls to 01 after the last day of the current month. That day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends on 29 when the BCD year is divisible by four (00 included) and on 28 otherwise.
- R6: A date carry out of month 12 sets the month to 01 and advances the year. A year carry from 99 inverts the century bit only when century enable is set.
- R7: While the stop bit is set, `tick` changes no time field.
- R8: A write to a clock byte in a cycle with `tick` loads the written value into that byte. The tick is dropped for that byte only. The other fields advance using the values held before the edge.
- R9: A write happens at a clock edge where `ce` and `we` are both high. The cycle after a read shows the byte that was held at that edge. The cycle after a write or an idle cycle shows 0x00.
- R10: While `pwr_fail` is high, writes are discarded and the next cycle's `rdata` is 0x00. `tick` still advances the clock.
- R11: Addresses below the window access a byte RAM indexed by the low `RAM_AW` address bits. The bytes 0x1FF1–0x1FF8 read back the last value written to them.
- R12: After reset the clock reads 00:00:00 on day 1, date 01, month 01, year 00. The century, enable, stop and test bits are all clear, and `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable |
| we | input | 1 | Write enable, qualified by `ce` |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, zero when not reading |
| tick | input | 1 | One-cycle pulse, once per second |
| pwr_fail | input | 1 | Power-fail deselect |

## Verification
The bench targets the carry chain at its extremes, which is a full rollover from 23:59:59 on 31 December 99. A wrong carry order would leave a field at its old value or fail to toggle the century bit. It drives the date rollover for February in leap years, in year 00 and in ordinary years, and for 30-day and 31-day months. A wrong month-length rule would show up as a 29, 31 or 32 where 01 is expected. The bench also asserts a write and a tick in the same cycle, which catches a design that lets the tick overwrite the written value. It writes all ones to the masked bytes, which exposes bits that are stored but should read as zero. Under power-fail it writes and reads, catching a design that stores the write, leaks read data or stops counting.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_READ,
        BUS_WRITE,
        BUS_PFAIL
    } bus_state_e;

    // All fields are 8 bits; unused high bits are held at zero by write masking
    typedef struct packed {
        logic       stop;
        logic       ftest;
        logic       cen_bit;
        logic       cen_en;
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] day;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
    } rtc_time_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic leap_year(input logic [7:0] yr);
        if (yr[4])
            return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        else
            return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bus_fsm.sv
module rtc_bus_fsm
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ce,
    input  logic       we,
    input  logic       pwr_fail,
    input  logic [7:0] rd_byte,
    output logic       wr_en,
    output logic [7:0] rdata
);

    bus_state_e state_q;
    bus_state_e state_d;
    logic [7:0] rd_q;

    always_comb begin
        if (pwr_fail)
            state_d = BUS_PFAIL;
        else if (ce && we)
            state_d = BUS_WRITE;
        else if (ce)
            state_d = BUS_READ;
        else
            state_d = BUS_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BUS_IDLE;
            rd_q    <= 8'h00;
        end else begin
            state_q <= state_d;
            if (state_d == BUS_READ)
                rd_q <= rd_byte;
        end
    end

    always_comb begin
        wr_en = (state_d == BUS_WRITE);
        unique case (state_q)
            BUS_READ:  rdata = rd_q;
            BUS_IDLE,
            BUS_WRITE,
            BUS_PFAIL: rdata = 8'h00;
            default:   rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [3:0] wr_off,
    input  logic [7:0] wdata,
    output rtc_time_t  now
);

    rtc_time_t q;
    logic adv, sec_c, min_c, hr_c, date_c, mon_c, yr_c;

    always_comb begin
        adv    = tick && !q.stop;
        sec_c  = adv    && (q.sec   >= 8'h59);
        min_c  = sec_c  && (q.min   >= 8'h59);
        hr_c   = min_c  && (q.hour  >= 8'h23);
        date_c = hr_c   && (q.date  >= month_last(q.month, q.year));
        mon_c  = date_c && (q.month >= 8'h12);
        yr_c   = mon_c  && (q.year  >= 8'h99);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.stop    <= 1'b0;
            q.ftest   <= 1'b0;
            q.cen_bit <= 1'b0;
            q.cen_en  <= 1'b0;
            q.sec     <= 8'h00;
            q.min     <= 8'h00;
            q.hour    <= 8'h00;
            q.day     <= 8'h01;
            q.date    <= 8'h01;
            q.month   <= 8'h01;
            q.year    <= 8'h00;
        end else begin
            // counting first; a write below overrides its own byte
            if (adv)
                q.sec <= sec_c ? 8'h00 : bcd_inc(q.sec);
            if (sec_c)
                q.min <= min_c ? 8'h00 : bcd_inc(q.min);
            if (min_c)
                q.hour <= hr_c ? 8'h00 : bcd_inc(q.hour);
            if (hr_c) begin
                q.day  <= (q.day >= 8'h07) ? 8'h01 : q.day + 8'h01;
                q.date <= date_c ? 8'h01 : bcd_inc(q.date);
            end
            if (date_c)
                q.month <= mon_c ? 8'h01 : bcd_inc(q.month);
            if (mon_c)
                q.year <= yr_c ? 8'h00 : bcd_inc(q.year);
            if (yr_c && q.cen_en)
                q.cen_bit <= !q.cen_bit;

            if (wr_en) begin
                case (wr_off)
                    4'h9: begin
                        q.stop <= wdata[7];
                        q.sec  <= wdata & 8'h7F;
                    end
                    4'hA: q.min <= wdata & 8'h7F;
                    4'hB: q.hour <= wdata & 8'h3F;
                    4'hC: begin
                        q.ftest   <= wdata[6];
                        q.cen_bit <= wdata[5];
                        q.cen_en  <= wdata[4];
                        q.day     <= wdata & 8'h07;
                    end
                    4'hD: q.date  <= wdata & 8'h3F;
                    4'hE: q.month <= wdata & 8'h1F;
                    4'hF: q.year  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assign now = q;

endmodule

// File: rtl/rtc_spare_regs.sv
module rtc_spare_regs #(
    parameter int N_BYTES = 8,
    localparam int IW = $clog2(N_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rd_byte
);

    logic [7:0] regs [N_BYTES];

    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= 8'h00;
            else if (wr_en && (idx == IW'(g)))
                regs[g] <= wdata;
        end
    end

    assign rd_byte = regs[idx];

endmodule

// File: rtl/rtc_byte_ram.sv
module rtc_byte_ram #(
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rd_byte
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[idx] <= wdata;
    end

    assign rd_byte = mem[idx];

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              tick,
    input  logic              pwr_fail
);

    localparam int N_SPARE = 8;
    localparam logic [ADDR_W-5:0] WIN_TAG = '1;

    logic       wr_en;
    logic       in_win;
    logic [3:0] off;
    logic       spare_hit;
    logic [2:0] spare_idx;
    logic [7:0] spare_rd;
    logic [7:0] ram_rd;
    logic [7:0] rd_byte;
    rtc_time_t  now;

    assign in_win    = (addr[ADDR_W-1:4] == WIN_TAG);
    assign off       = addr[3:0];
    assign spare_hit = in_win && (off != 4'h0) && (off <= 4'h8);
    assign spare_idx = off[2:0] - 3'd1;

    rtc_bus_fsm u_bus (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .we       (we),
        .pwr_fail (pwr_fail),
        .rd_byte  (rd_byte),
        .wr_en    (wr_en),
        .rdata    (rdata)
    );

    rtc_calendar u_cal (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .wr_en  (wr_en && in_win),
        .wr_off (off),
        .wdata  (wdata),
        .now    (now)
    );

    rtc_spare_regs #(.N_BYTES(N_SPARE)) u_spare (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en && spare_hit),
        .idx     (spare_idx),
        .wdata   (wdata),
        .rd_byte (spare_rd)
    );

    rtc_byte_ram #(.AW(RAM_AW)) u_ram (
        .clk     (clk),
        .wr_en   (wr_en && !in_win),
        .idx     (addr[RAM_AW-1:0]),
        .wdata   (wdata),
        .rd_byte (ram_rd)
    );

    always_comb begin
        if (!in_win) begin
            rd_byte = ram_rd;
        end else begin
            unique case (off)
                4'h0: rd_byte = 8'h00;
                4'h1, 4'h2, 4'h3, 4'h4,
                4'h5, 4'h6, 4'h7, 4'h8: rd_byte = spare_rd;
                4'h9: rd_byte = now.sec | {now.stop, 7'b0};
                4'hA: rd_byte = now.min;
                4'hB: rd_byte = now.hour;
                4'hC: rd_byte = now.day | {1'b0, now.ftest, now.cen_bit, now.cen_en, 4'b0};
                4'hD: rd_byte = now.date;
                4'hE: rd_byte = now.month;
                4'hF: rd_byte = now.year;
                default: rd_byte = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
    import rtc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ce,
    input logic       we,
    input logic       pwr_fail,
    input logic       tick,
    input logic [7:0] rdata,
    input rtc_time_t  now
);

    AST_PF_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> (rdata == 8'h00)); // R10

    AST_PF_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (pwr_fail && !tick) |=> (now == $past(now))); // R10

    AST_WRITE_HIDES_READ: assert property (@(posedge clk) disable iff (rst)
        (ce && we) |=> (rdata == 8'h00)); // R9

    AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ce |=> (rdata == 8'h00)); // R9

    AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (now.stop && !(ce && we)) |=> (now.sec == $past(now.sec))); // R7

    AST_TICK_MOVES_SEC: assert property (@(posedge clk) disable iff (rst)
        (tick && !now.stop && !(ce && we)) |=> (now.sec != $past(now.sec))); // R4

endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .we       (we),
    .pwr_fail (pwr_fail),
    .tick     (tick),
    .rdata    (rdata),
    .now      (now)
);

// File: tb/rtc_regfile_tb.sv
module rtc_regfile_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce = 1'b0;
    logic        we = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        tick = 1'b0;
    logic        pwr_fail = 1'b0;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    rtc_regfile u_dut (
        .clk(clk), .rst(rst), .ce(ce), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick), .pwr_fail(pwr_fail)
    );

    // {address(16), write data, expected read-back}
    localparam logic [31:0] VEC [12] = '{
        {16'h1FFE, 8'hF2, 8'h12},  // R2 month high bits
        {16'h1FFD, 8'hE5, 8'h25},  // R2 date high bits
        {16'h1FFB, 8'hD3, 8'h13},  // R2 hour high bits
        {16'h1FFA, 8'hC7, 8'h47},  // R2 minute bit 7
        {16'h1FF9, 8'h34, 8'h34},  // R1 seconds
        {16'h1FFC, 8'hBF, 8'h37},  // R1 R2 century/day byte
        {16'h1FFF, 8'h42, 8'h42},  // R1 year
        {16'h1FF8, 8'hA5, 8'hA5},  // R11 storage
        {16'h1FF3, 8'h5A, 8'h5A},  // R11 storage
        {16'h1FF0, 8'hFF, 8'h00},  // R3 read-only flags
        {16'h0010, 8'h11, 8'h11},  // R11 RAM
        {16'h0023, 8'h77, 8'h77}   // R11 RAM
    };

    // {year, month, date, expected date, expected month}
    localparam logic [39:0] ROLL [7] = '{
        {8'h24, 8'h02, 8'h28, 8'h29, 8'h02},
        {8'h24, 8'h02, 8'h29, 8'h01, 8'h03},
        {8'h23, 8'h02, 8'h28, 8'h01, 8'h03},
        {8'h00, 8'h02, 8'h28, 8'h29, 8'h02},
        {8'h21, 8'h04, 8'h30, 8'h01, 8'h05},
        {8'h21, 8'h01, 8'h31, 8'h01, 8'h02},
        {8'h22, 8'h07, 8'h30, 8'h31, 8'h07}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        ce = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        ce = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [12:0] a, output logic [7:0] v);
        @(negedge clk);
        ce = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        v = rdata;
        ce = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_eod(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] dt);
        bus_wr(13'h1FFF, y);
        bus_wr(13'h1FFE, mo);
        bus_wr(13'h1FFD, dt);
        bus_wr(13'h1FFB, 8'h23);
        bus_wr(13'h1FFA, 8'h59);
        bus_wr(13'h1FF9, 8'h59);
    endtask

    initial begin
        repeat (500000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 rdata after reset", rdata, 8'h00);
        bus_rd(13'h1FF9, v); chk("R12 seconds", v, 8'h00);
        bus_rd(13'h1FFC, v); chk("R12 day byte", v, 8'h01);
        bus_rd(13'h1FFD, v); chk("R12 date", v, 8'h01);
        bus_rd(13'h1FFE, v); chk("R12 month", v, 8'h01);
        bus_rd(13'h1FFF, v); chk("R12 year", v, 8'h00);

        for (int i = 0; i < 12; i++) begin
            bus_wr(VEC[i][28:16], VEC[i][15:8]);
            bus_rd(VEC[i][28:16], v);
            chk("R1 R2 R3 R11 vector", v, VEC[i][7:0]);
        end
        bus_rd(13'h0123, v); chk("R11 RAM alias", v, 8'h77);

        // R9: rdata after a write cycle
        @(negedge clk);
        ce = 1'b1; we = 1'b1; addr = 13'h1FF4; wdata = 8'h66;
        @(negedge clk);
        chk("R9 rdata during write", rdata, 8'h00);
        ce = 1'b0; we = 1'b0;
        @(negedge clk);
        chk("R9 rdata idle", rdata, 8'h00);

        // R4 R6 full rollover with century enable
        bus_wr(13'h1FFC, 8'h17);
        set_eod(8'h99, 8'h12, 8'h31);
        pulse_tick();
        bus_rd(13'h1FF9, v); chk("R4 sec wrap", v, 8'h00);
        bus_rd(13'h1FFA, v); chk("R4 min wrap", v, 8'h00);
        bus_rd(13'h1FFB, v); chk("R4 hour wrap", v, 8'h00);
        bus_rd(13'h1FFC, v); chk("R6 century toggle day wrap", v, 8'h31);
        bus_rd(13'h1FFD, v); chk("R6 date", v, 8'h01);
        bus_rd(13'h1FFE, v); chk("R6 month", v, 8'h01);
        bus_rd(13'h1FFF, v); chk("R6 year wrap", v, 8'h00);

        // R6 century enable clear
        bus_wr(13'h1FFC, 8'h26);
        set_eod(8'h99, 8'h12, 8'h31);
        pulse_tick();
        bus_rd(13'h1FFC, v); chk("R6 century held", v, 8'h27);

        // R5 month lengths
        for (int i = 0; i < 7; i++) begin
            set_eod(ROLL[i][39:32], ROLL[i][31:24], ROLL[i][23:16]);
            pulse_tick();
            bus_rd(13'h1FFD, v); chk("R5 date", v, ROLL[i][15:8]);
            bus_rd(13'h1FFE, v); chk("R5 month", v, ROLL[i][7:0]);
        end

        // R7 stop bit
        bus_wr(13'h1FF9, 8'h90);
        pulse_tick();
        bus_rd(13'h1FF9, v); chk("R7 stopped", v, 8'h90);
        bus_wr(13'h1FF9, 8'h10);
        pulse_tick();
        bus_rd(13'h1FF9, v); chk("R7 running", v, 8'h11);

        // R8 write and tick in one cycle
        bus_wr(13'h1FF9, 8'h59);
        bus_wr(13'h1FFA, 8'h10);
        @(negedge clk);
        ce = 1'b1; we = 1'b1; addr = 13'h1FFA; wdata = 8'h30; tick = 1'b1;
        @(negedge clk);
        ce = 1'b0; we = 1'b0; tick = 1'b0;
        bus_rd(13'h1FFA, v); chk("R8 written minute kept", v, 8'h30);
        bus_rd(13'h1FF9, v); chk("R8 seconds still advance", v, 8'h00);
        @(negedge clk);
        ce = 1'b1; we = 1'b1; addr = 13'h1FF9; wdata = 8'h20; tick = 1'b1;
        @(negedge clk);
        ce = 1'b0; we = 1'b0; tick = 1'b0;
        bus_rd(13'h1FF9, v); chk("R8 written second kept", v, 8'h20);

        // R10 power fail
        bus_wr(13'h1FF9, 8'h05);
        @(negedge clk);
        pwr_fail = 1'b1;
        bus_wr(13'h1FF9, 8'h45);
        chk("R10 rdata after write", rdata, 8'h00);
        bus_rd(13'h1FF9, v); chk("R10 read blocked", v, 8'h00);
        pulse_tick();
        @(negedge clk);
        pwr_fail = 1'b0;
        bus_rd(13'h1FF9, v); chk("R10 write dropped tick kept", v, 8'h06);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule